// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two event counters of configurable width (32 bits by default), called the even and the odd counter. Each counter has its own event-type register. The code in that register picks which input pulse the counter counts: memory-access pulses or cycle pulses. One special code on the odd counter links the pair. While it is set, the odd counter does not count input pulses. Instead it counts the wraps of the even counter, so the pair behaves as one counter of twice the width.

Software controls the block with plain write strobes. A write-one-to-set mask and a write-one-to-clear mask turn the per-counter enables on and off. A write-one-to-clear mask acknowledges the sticky overflow flags. A direct load port writes either counter. A global enable gates all counting. The linkage, the enables and the event types can all change while the counters run, and each change applies from the next counted event or wrap.

Top module: `evp_pair_top`

## Requirements
- R1: After reset, both counters read 0, both enables read 0 and both overflow flags read 0.
- R2: Event-type code 0x13 selects memory-access pulses and code 0x11 selects cycle pulses. Any other code counts nothing. A selected pulse on an enabled counter adds 1, and the new value shows on the outputs one clock later.
- R3: While the global enable is 0, no counter changes, except through a direct load.
- R4: Enable masks use bit 0 for the even counter and bit 1 for the odd counter. A 1 bit in the set mask turns that enable on, and a 1 bit in the clear mask turns it off. A 0 bit leaves the enable unchanged. When the same bit is set and cleared in one cycle, the clear wins.
- R5: When the odd type is the link code 0x1E, the odd counter never changes while the even counter is disabled, even if the odd counter is enabled.
- R6: When the even counter wraps from all ones to 0 and the pair is not both linked and odd-enabled, overflow bit 0 is set. A linked odd counter that is disabled stays unchanged.
- R7: When the pair is linked and both counters are enabled, an even wrap adds exactly 1 to the odd counter and does not set overflow bit 0.
- R8: An even counter loaded with 0xFFFFFFDC and given 40 counted events wraps exactly once and then reads 4.
- R9: A change of the odd enable or the odd event type, made while the counters run, decides the outcome of the next even wrap. After the odd type is switched from the link code to 0x11, a wrap sets overflow bit 0.
- R10: The overflow register is write-one-to-clear: a 1 bit clears that flag and a 0 bit has no effect. A flag set in the same cycle as its clear stays set.
- R11: A wrap of the odd counter from all ones to 0 sets overflow bit 1.
- R12: A direct load of a counter takes priority over an increment in the same cycle, and its value reads back exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global count enable |
| en_set_we | input | 1 | Strobe: apply en_mask as a set mask |
| en_clr_we | input | 1 | Strobe: apply en_mask as a clear mask |
| en_mask | input | 2 | Enable mask, bit 0 even, bit 1 odd |
| ovf_clr_we | input | 1 | Strobe: clear overflow flags given in ovf_mask |
| ovf_mask | input | 2 | Overflow clear mask |
| type_we | input | 2 | Per-counter event-type write strobe |
| type_wdata | input | 8 | Event-type code to write |
| load_we | input | 2 | Per-counter direct load strobe |
| load_data | input | 32 | Value for a direct load |
| mem_evt | input | 1 | Memory-access event pulse |
| cyc_evt | input | 1 | Cycle event pulse |
| cnt_even | output | 32 | Even counter value |
| cnt_odd | output | 32 | Odd counter value |
| en_q | output | 2 | Enable state |
| ovf_q | output | 2 | Overflow flags |

## Verification
Every result of this block is registered. An event pulse, a load, an enable or type write, or an overflow clear that is present at one rising edge shows on the counter, enable or flag outputs directly after that edge. A wrap adds to a linked odd counter in the same edge as the even counter rolls over, with no extra delay. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a cycle after the update. So each check sees exactly one clock of effect per stimulus cycle.

// File: rtl/evp_pkg.sv
package evp_pkg;
  localparam int unsigned EVT_W = 8;
  localparam logic [EVT_W-1:0] EVT_MEM   = 8'h13;
  localparam logic [EVT_W-1:0] EVT_CYC   = 8'h11;
  localparam logic [EVT_W-1:0] EVT_CHAIN = 8'h1E;
  localparam int unsigned NCNT = 2;
endpackage

// File: rtl/evp_sel.sv
module evp_sel
  import evp_pkg::*;
(
  input  logic [EVT_W-1:0] code,
  input  logic             mem_evt,
  input  logic             cyc_evt,
  output logic             hit,
  output logic             is_chain
);
  always_comb begin
    hit      = 1'b0;
    is_chain = (code == EVT_CHAIN);
    unique case (code)
      EVT_MEM: hit = mem_evt;
      EVT_CYC: hit = cyc_evt;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/evp_counter.sv
module evp_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = wr_en | inc;
    wrap   = inc & ~wr_en & (&cnt_q);
    cnt_d  = cnt_q;
    if (wr_en)    cnt_d = wr_data;
    else if (inc) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data));
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/evp_ctrl.sv
module evp_ctrl
  import evp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_set_we,
  input  logic                       en_clr_we,
  input  logic [NCNT-1:0]            en_mask,
  input  logic                       ovf_clr_we,
  input  logic [NCNT-1:0]            ovf_mask,
  input  logic [NCNT-1:0]            ovf_set,
  input  logic [NCNT-1:0]            type_we,
  input  logic [EVT_W-1:0]           type_wdata,
  output logic [NCNT-1:0]            en_q,
  output logic [NCNT-1:0]            ovf_q,
  output logic [NCNT-1:0][EVT_W-1:0] type_q
);
  logic [NCNT-1:0] en_d, ovf_d, set_m, clr_m, oclr_m;
  logic            en_ce, ovf_ce;

  always_comb begin
    set_m  = en_set_we  ? en_mask  : '0;
    clr_m  = en_clr_we  ? en_mask  : '0;
    oclr_m = ovf_clr_we ? ovf_mask : '0;
    en_ce  = en_set_we | en_clr_we;
    en_d   = (en_q | set_m) & ~clr_m;
    ovf_ce = ovf_clr_we | (|ovf_set);
    ovf_d  = (ovf_q & ~oclr_m) | ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= '0;
    else if (ovf_ce) ovf_q <= ovf_d;
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_type
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          type_q[i] <= '0;
      else if (type_we[i]) type_q[i] <= type_wdata;
    end
  end

  p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_we && !en_clr_we) |=> ((en_q & $past(en_mask)) == $past(en_mask)));
  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> ((en_q & $past(en_mask)) == '0));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_clr_we |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
endmodule

// File: rtl/evp_pair_top.sv
module evp_pair_top
  import evp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [1:0]       en_mask,
  input  logic             ovf_clr_we,
  input  logic [1:0]       ovf_mask,
  input  logic [1:0]       type_we,
  input  logic [7:0]       type_wdata,
  input  logic [1:0]       load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             mem_evt,
  input  logic             cyc_evt,
  output logic [CNT_W-1:0] cnt_even,
  output logic [CNT_W-1:0] cnt_odd,
  output logic [1:0]       en_q,
  output logic [1:0]       ovf_q
);
  logic [NCNT-1:0][EVT_W-1:0] type_q;
  logic [NCNT-1:0][CNT_W-1:0] cnt_q;
  logic [NCNT-1:0]            hit, is_chain, inc, wrap, ovf_set;
  logic                       linked;

  evp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set_we  (en_set_we),
    .en_clr_we  (en_clr_we),
    .en_mask    (en_mask),
    .ovf_clr_we (ovf_clr_we),
    .ovf_mask   (ovf_mask),
    .ovf_set    (ovf_set),
    .type_we    (type_we),
    .type_wdata (type_wdata),
    .en_q       (en_q),
    .ovf_q      (ovf_q),
    .type_q     (type_q)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    evp_sel u_sel (
      .code     (type_q[i]),
      .mem_evt  (mem_evt),
      .cyc_evt  (cyc_evt),
      .hit      (hit[i]),
      .is_chain (is_chain[i])
    );
    evp_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (load_we[i]),
      .wr_data (load_data),
      .inc     (inc[i]),
      .cnt_q   (cnt_q[i]),
      .wrap    (wrap[i])
    );
  end

  always_comb begin
    linked     = is_chain[1];
    inc[0]     = glob_en & en_q[0] & hit[0];
    inc[1]     = linked ? (wrap[0] & en_q[1]) : (glob_en & en_q[1] & hit[1]);
    ovf_set[0] = wrap[0] & ~(linked & en_q[1]);
    ovf_set[1] = wrap[1];
    cnt_even   = cnt_q[0];
    cnt_odd    = cnt_q[1];
  end

  p_link_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && !en_q[0] && !load_we[1]) |=> $stable(cnt_odd));
  p_ovf_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap[0] && !(linked && en_q[1])) |=> ovf_q[0]);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap[0] && linked && en_q[1] && !ovf_q[0]) |=> !ovf_q[0]);
  p_ovf_odd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |=> ovf_q[1]);
  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && load_we == 2'b00) |=> ($stable(cnt_even) && $stable(cnt_odd)));
endmodule

// File: tb/evp_pair_top_bench.sv
module evp_pair_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glob_en = 1'b0, en_set_we = 1'b0, en_clr_we = 1'b0, ovf_clr_we = 1'b0;
  logic [1:0]  en_mask = '0, ovf_mask = '0, type_we = '0, load_we = '0;
  logic [7:0]  type_wdata = '0;
  logic [31:0] load_data = '0;
  logic        mem_evt = 1'b0, cyc_evt = 1'b0;
  logic [31:0] cnt_even, cnt_odd;
  logic [1:0]  en_q, ovf_q;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  evp_pair_top u_evp_pair_top (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en),
    .en_set_we(en_set_we), .en_clr_we(en_clr_we), .en_mask(en_mask),
    .ovf_clr_we(ovf_clr_we), .ovf_mask(ovf_mask),
    .type_we(type_we), .type_wdata(type_wdata),
    .load_we(load_we), .load_data(load_data),
    .mem_evt(mem_evt), .cyc_evt(cyc_evt),
    .cnt_even(cnt_even), .cnt_odd(cnt_odd), .en_q(en_q), .ovf_q(ovf_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic en_set(input logic [1:0] m);
    en_mask = m; en_set_we = 1'b1; @(negedge clk); en_set_we = 1'b0;
  endtask
  task automatic en_clr(input logic [1:0] m);
    en_mask = m; en_clr_we = 1'b1; @(negedge clk); en_clr_we = 1'b0;
  endtask
  task automatic ovf_clr(input logic [1:0] m);
    ovf_mask = m; ovf_clr_we = 1'b1; @(negedge clk); ovf_clr_we = 1'b0;
  endtask
  task automatic set_type(input int idx, input logic [7:0] c);
    type_wdata = c; type_we = (idx == 0) ? 2'b01 : 2'b10; @(negedge clk); type_we = '0;
  endtask
  task automatic load(input int idx, input logic [31:0] v);
    load_data = v; load_we = (idx == 0) ? 2'b01 : 2'b10; @(negedge clk); load_we = '0;
  endtask
  task automatic pulses(input int n, input logic m, input logic c);
    for (int k = 0; k < n; k++) begin
      mem_evt = m; cyc_evt = c; @(negedge clk);
    end
    mem_evt = 1'b0; cyc_evt = 1'b0;
  endtask
  task automatic clean();
    en_clr(2'b11); ovf_clr(2'b11); load(0, 32'h0); load(1, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 even", cnt_even, 0); chk("R1 odd", cnt_odd, 0);
    chk("R1 en", {30'd0, en_q}, 0); chk("R1 ovf", {30'd0, ovf_q}, 0);

    // R2 event selection
    glob_en = 1'b1;
    set_type(0, 8'h13); en_set(2'b01);
    pulses(20, 1'b1, 1'b0);
    chk("R2 mem count", cnt_even, 20);
    pulses(7, 1'b0, 1'b1);
    chk("R2 cyc ignored when mem type", cnt_even, 20);
    set_type(0, 8'h11); pulses(5, 1'b0, 1'b1);
    chk("R2 cyc count", cnt_even, 25);
    set_type(0, 8'h22); pulses(5, 1'b1, 1'b1);
    chk("R2 other code", cnt_even, 25);
    set_type(0, 8'h13);

    // R3 global enable
    glob_en = 1'b0; pulses(6, 1'b1, 1'b1);
    chk("R3 gated", cnt_even, 25);
    glob_en = 1'b1;

    // R4 enable masks
    en_set(2'b00); chk("R4 set zero", {30'd0, en_q}, 32'd1);
    en_clr(2'b00); chk("R4 clr zero", {30'd0, en_q}, 32'd1);
    en_set(2'b10); chk("R4 set odd", {30'd0, en_q}, 32'd3);
    en_mask = 2'b01; en_set_we = 1'b1; en_clr_we = 1'b1; @(negedge clk);
    en_set_we = 1'b0; en_clr_we = 1'b0;
    chk("R4 clear wins", {30'd0, en_q}, 32'd2);
    en_clr(2'b11); chk("R4 clr both", {30'd0, en_q}, 32'd0);

    // R5 linked odd with even disabled
    clean(); set_type(1, 8'h1E); en_set(2'b10);
    pulses(20, 1'b1, 1'b0);
    chk("R5 even", cnt_even, 0); chk("R5 odd", cnt_odd, 0);

    // R6 wrap with odd disabled
    clean(); load(0, 32'hFFFFFFF0); en_set(2'b01);
    pulses(20, 1'b1, 1'b0);
    chk("R6 even", cnt_even, 4); chk("R6 odd", cnt_odd, 0);
    chk("R6 ovf", {30'd0, ovf_q}, 1);

    // R7 R8 linked, both enabled
    clean(); load(0, 32'hFFFFFFDC); en_set(2'b11);
    pulses(40, 1'b1, 1'b0);
    chk("R8 even after 40", cnt_even, 4);
    chk("R7 odd +1", cnt_odd, 1); chk("R7 no ovf", {30'd0, ovf_q}, 0);

    // R9 enable odd mid run
    clean(); load(0, 32'hFFFFFFDC); en_set(2'b01);
    pulses(20, 1'b1, 1'b0); en_set(2'b11); pulses(20, 1'b1, 1'b0);
    chk("R9 late enable odd", cnt_odd, 1); chk("R9 late enable ovf", {30'd0, ovf_q}, 0);

    // R9 cycles -> link
    clean(); set_type(1, 8'h11); load(0, 32'hFFFFFFDC); en_set(2'b11);
    pulses(20, 1'b1, 1'b0);
    set_type(1, 8'h1E); load(1, 0);
    pulses(20, 1'b1, 1'b0);
    chk("R9 to link odd", cnt_odd, 1); chk("R9 to link ovf", {30'd0, ovf_q}, 0);

    // R9 link -> cycles
    clean(); load(0, 32'hFFFFFFDC); en_set(2'b11);
    pulses(20, 1'b1, 1'b0);
    set_type(1, 8'h11);
    pulses(20, 1'b1, 1'b0);
    chk("R9 from link ovf", {30'd0, ovf_q}, 1); chk("R9 from link odd", cnt_odd, 0);

    // R10 overflow clear
    ovf_clr(2'b00); chk("R10 zero mask", {30'd0, ovf_q}, 1);
    ovf_clr(2'b01); chk("R10 cleared", {30'd0, ovf_q}, 0);
    set_type(1, 8'h1E); en_clr(2'b10);
    load(0, 32'hFFFFFFFF);
    ovf_mask = 2'b01; ovf_clr_we = 1'b1; mem_evt = 1'b1; @(negedge clk);
    ovf_clr_we = 1'b0; mem_evt = 1'b0;
    chk("R10 set beats clear", {30'd0, ovf_q}, 1);

    // R11 odd wrap in linked mode
    clean(); load(0, 32'hFFFFFFFF); load(1, 32'hFFFFFFFF); en_set(2'b11);
    pulses(1, 1'b1, 1'b0);
    chk("R11 odd wrapped", cnt_odd, 0); chk("R11 ovf", {30'd0, ovf_q}, 2);

    // R12 load beats increment
    clean(); en_set(2'b01);
    load_data = 32'h1234; load_we = 2'b01; mem_evt = 1'b1; @(negedge clk);
    load_we = '0; mem_evt = 1'b0;
    chk("R12 load wins", cnt_even, 32'h1234);

    // R6 R7 R9 sweep over enables and linkage
    for (int e = 0; e < 4; e++) begin
      for (int l = 0; l < 2; l++) begin
        clean();
        set_type(1, (l != 0) ? 8'h1E : 8'h11);
        load(0, 32'hFFFFFFFE); load(1, 32'd5);
        en_set(e[1:0]);
        pulses(3, 1'b1, 1'b0);
        chk("R6/R7 sweep even", cnt_even, e[0] ? 32'd1 : 32'hFFFFFFFE);
        chk("R7 sweep odd", cnt_odd, (l != 0 && e == 3) ? 32'd6 : 32'd5);
        chk("R6 sweep ovf", {30'd0, ovf_q},
            (e[0] && !(l != 0 && e[1])) ? 32'd1 : 32'd0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule